// File: doc/BRIEF.md
# Multi-Mode Run-Length Stream Decoder

This block expands a compressed byte stream into a plain byte stream. Every group in the compressed stream starts with a command byte. The value of that byte selects one of five actions: a literal copy that is sent out in reverse order, an incrementing sequence, a fill that alternates between two bytes, a run of one repeated byte, or the end of the stream. Compressed bytes arrive on a valid/ready byte port. Decoded bytes leave on a second valid/ready port. Each decoded byte carries a destination address.

To use the block, software or a sequencer pulses `start` with a base address. It then feeds the compressed stream until the terminator command has been taken. Output addresses begin at the base and go up by one for each byte emitted. After the terminator, `done` rises once the last decoded byte has left. The input port then stays closed, so the byte that follows the terminator is never consumed. A new `start` pulse is needed before another stream can be decoded.

Literal bytes are collected in a small buffer that can be inferred as block RAM. They are replayed from the last byte received to the first. The input side is held off while any group is being emitted, so back-pressure on the output reaches all the way to the input.

Top module: `rle_stream_decoder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `done` are low, and they stay low until `start` is pulsed, even while `in_valid` is held high.
- R2: `start` loads `base_addr`. The first decoded byte carries that address, and each following byte carries the previous address plus one, wrapping at the address width.
- R3: A command byte c with c[7:6]=00 (values 0x00 to 0x3F) is followed by c+1 data bytes. All of them are taken in before any is emitted, and they come out in reverse order of arrival.
- R4: The command byte 0x40 ends the stream. Once every earlier byte has been delivered, `done` goes high. While `done` is high, `in_ready` stays low and no further bytes are emitted.
- R5: A command byte in 0x41 to 0x7F is followed by one operand b. The block emits c−0x3F bytes: b, b+1, b+2 and so on, each modulo 256.
- R6: A command byte in 0x80 to 0x9F is followed by operands b1 and then b2. The block emits c−0x7F bytes that alternate b1, b2, b1, and so on, always starting with b1.
- R7: A command byte in 0xA0 to 0xFF is followed by one operand b. The block emits b exactly 0x101−c times, which is 97 copies for 0xA0 and 2 copies for 0xFF.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_addr` hold their values. Every decoded byte is delivered exactly once.
- R9: While a group is being emitted, `in_ready` is low, so a stalled output also stalls the compressed input.
- R10: A `start` pulse after completion clears `done` on the next cycle and decodes a new stream from the new base address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new stream |
| base_addr | input | AW | Destination address of the first decoded byte, loaded on `start` |
| in_data | input | 8 | Compressed byte |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Decoder accepts `in_data` this cycle |
| out_data | output | 8 | Decoded byte |
| out_addr | output | AW | Destination address of `out_data` |
| out_valid | output | 1 | `out_data` and `out_addr` are valid |
| out_ready | input | 1 | Sink takes the decoded byte this cycle |
| done | output | 1 | Terminator reached and all output drained |

## Verification
The bench sweeps every command value except the terminator through one long stream, and it applies random gaps on both handshakes. This covers the range edges 0x00, 0x3F, 0x41, 0x7F, 0x80, 0x9F, 0xA0 and 0xFF. If the count were off by one at any of these edges, every later byte and address would shift. If the literal replay had the wrong buffer read latency, bytes would be duplicated or skipped. If the alternating fill did not always start from b1, every single-byte group from 0x80 would come out wrong. A directed case lets an incrementing sequence pass 0xFF and lets the address pass its top value, to catch missing wraps. Another case holds the output stalled while a 97-byte run is pending, to show that the input stays closed and the pending byte stays stable. A decoder that went on taking input after the terminator, or that kept `done` high after a restart, fails the checks made after each stream.

// File: rtl/rle_dec_pkg.sv
package rle_dec_pkg;

  // Width of the literal count field in a command byte; sets replay depth.
  localparam int LIT_FIELD_W = 6;
  localparam int CNT_W       = 9;   // holds 1..97

  typedef enum logic [2:0] {
    K_LIT,
    K_END,
    K_SEQ,
    K_DBL,
    K_RUN
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_OP1,
    S_OP2,
    S_FILL,
    S_PREP,
    S_EMIT,
    S_DONE
  } dec_state_e;

  function automatic cmd_kind_e classify(input logic [7:0] c);
    if (c[7:6] == 2'b00)      return K_LIT;
    else if (c == 8'h40)      return K_END;
    else if (c[7:6] == 2'b01) return K_SEQ;
    else if (c[7:5] == 3'b100) return K_DBL;
    else                      return K_RUN;
  endfunction

  // Number of bytes a fill command produces.
  function automatic logic [CNT_W-1:0] fill_count(input logic [7:0] c);
    case (classify(c))
      K_SEQ:   return CNT_W'(c[5:0]) + CNT_W'(1);
      K_DBL:   return CNT_W'(c[4:0]) + CNT_W'(1);
      K_RUN:   return CNT_W'(257) - CNT_W'(c);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/rle_lit_buf.sv
// Simple dual-port byte store with registered read, suitable for block RAM.
module rle_lit_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW_B = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_B-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AW_B-1:0] raddr,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rle_out_reg.sv
// Registered output slot with the destination address counter.
module rle_out_reg #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          can_push,
  output logic [DW-1:0] out_data,
  output logic [AW-1:0] out_addr,
  output logic          out_valid,
  input  logic          out_ready
);

  logic [AW-1:0] next_addr_q;

  assign can_push = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_addr    <= '0;
      next_addr_q <= '0;
    end else begin
      if (start) next_addr_q <= base_addr;
      if (push) begin
        out_valid   <= 1'b1;
        out_data    <= push_data;
        out_addr    <= next_addr_q;
        next_addr_q <= next_addr_q + AW'(1);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rle_ctrl.sv
// Command parser, operand capture, count generation and literal replay.
module rle_ctrl
  import rle_dec_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LIT_DEPTH = 1 << LIT_FIELD_W,
  localparam int LA       = $clog2(LIT_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          buf_we,
  output logic [LA-1:0] buf_waddr,
  output logic [DW-1:0] buf_wdata,
  output logic [LA-1:0] buf_raddr,
  input  logic [DW-1:0] buf_rdata,
  input  logic          can_push,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          finished
);

  dec_state_e     state_q;
  cmd_kind_e      kind_q;
  logic [LA-1:0]  idx_q;
  logic [LA-1:0]  last_q;
  logic [CNT_W-1:0] rem_q;
  logic [DW-1:0]  val_q;
  logic [DW-1:0]  alt_q;
  logic           in_fire;

  always_comb begin
    in_ready = !start && (state_q == S_CMD || state_q == S_OP1 ||
                          state_q == S_OP2 || state_q == S_FILL);
  end

  assign in_fire   = in_valid && in_ready;
  assign push      = !start && (state_q == S_EMIT) && can_push;
  assign push_data = (kind_q == K_LIT) ? buf_rdata : val_q;
  assign finished  = (state_q == S_DONE);

  assign buf_we    = (state_q == S_FILL) && in_fire;
  assign buf_waddr = idx_q;
  assign buf_wdata = in_data;
  // Read one slot ahead when the current byte leaves, so data is ready next cycle.
  assign buf_raddr = push ? idx_q - LA'(1) : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      kind_q  <= K_END;
      idx_q   <= '0;
      last_q  <= '0;
      rem_q   <= '0;
      val_q   <= '0;
      alt_q   <= '0;
    end else if (start) begin
      state_q <= S_CMD;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        S_CMD: if (in_fire) begin
          kind_q <= classify(in_data);
          rem_q  <= fill_count(in_data);
          unique case (classify(in_data))
            K_LIT: begin
              last_q  <= in_data[LA-1:0];
              idx_q   <= '0;
              state_q <= S_FILL;
            end
            K_END:   state_q <= S_DONE;
            default: state_q <= S_OP1;
          endcase
        end
        S_FILL: if (in_fire) begin
          if (idx_q == last_q) begin
            rem_q   <= CNT_W'(last_q) + CNT_W'(1);
            state_q <= S_PREP;
          end else begin
            idx_q <= idx_q + LA'(1);
          end
        end
        S_PREP: state_q <= S_EMIT;
        S_OP1: if (in_fire) begin
          val_q   <= in_data;
          state_q <= (kind_q == K_DBL) ? S_OP2 : S_EMIT;
        end
        S_OP2: if (in_fire) begin
          alt_q   <= in_data;
          state_q <= S_EMIT;
        end
        S_EMIT: if (push) begin
          rem_q <= rem_q - CNT_W'(1);
          unique case (kind_q)
            K_LIT:   idx_q <= idx_q - LA'(1);
            K_SEQ:   val_q <= val_q + DW'(1);
            K_DBL: begin
              val_q <= alt_q;
              alt_q <= val_q;
            end
            default: ;
          endcase
          if (rem_q == CNT_W'(1)) state_q <= S_CMD;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rle_stream_decoder.sv
module rle_stream_decoder
  import rle_dec_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LIT_DEPTH = 1 << LIT_FIELD_W,
  localparam int DW       = 8,
  localparam int LA       = $clog2(LIT_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic [AW-1:0] out_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          done
);

  logic          buf_we;
  logic [LA-1:0] buf_waddr;
  logic [DW-1:0] buf_wdata;
  logic [LA-1:0] buf_raddr;
  logic [DW-1:0] buf_rdata;
  logic          can_push;
  logic          push;
  logic [DW-1:0] push_data;
  logic          finished;

  rle_ctrl #(.DW(DW), .LIT_DEPTH(LIT_DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .buf_raddr (buf_raddr),
    .buf_rdata (buf_rdata),
    .can_push  (can_push),
    .push      (push),
    .push_data (push_data),
    .finished  (finished)
  );

  rle_lit_buf #(.DW(DW), .DEPTH(LIT_DEPTH)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  rle_out_reg #(.DW(DW), .AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .base_addr (base_addr),
    .push      (push),
    .push_data (push_data),
    .can_push  (can_push),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );

  assign done = finished && !out_valid;

endmodule

// File: rtl/rle_stream_decoder_chk.sv
module rle_stream_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic          in_ready,
  input logic [7:0]    out_data,
  input logic [AW-1:0] out_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic          done
);

  logic [AW-1:0] exp_addr_q;
  logic          track_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_addr_q <= '0;
      track_q    <= 1'b0;
    end else if (start) begin
      exp_addr_q <= base_addr;
      track_q    <= !out_valid;
    end else if (out_valid && out_ready) begin
      exp_addr_q <= out_addr + AW'(1);
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !in_ready && !done));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (track_q && out_valid && out_ready) |-> (out_addr == exp_addr_q));

  a_r4_done_closes_input: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  a_r4_done_drained: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

  a_r10_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

endmodule

bind rle_stream_decoder rle_stream_decoder_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .base_addr (base_addr),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_addr  (out_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done)
);

// File: tb/rle_stream_decoder_tb.sv
module rle_stream_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] base_addr;
  logic [7:0]    in_data;
  logic          in_valid;
  logic          in_ready;
  logic [7:0]    out_data;
  logic [AW-1:0] out_addr;
  logic          out_valid;
  logic          out_ready;
  logic          done;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_stream_decoder #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_addr(out_addr), .out_valid(out_valid),
    .out_ready(out_ready), .done(done)
  );

  int checks = 0;
  int failures = 0;
  bit wd_hit = 1'b0;
  logic [31:0] rs = 32'h1234_5679;

  logic [7:0]    strm[$];
  logic [7:0]    exp_d[$];
  logic [AW-1:0] exp_a[$];
  string         exp_r[$];

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // Reference expansion of the stream, computed from the requirements.
  task automatic model(input logic [AW-1:0] base);
    logic [AW-1:0] a = base;
    int i = 0;
    exp_d.delete(); exp_a.delete(); exp_r.delete();
    while (i < strm.size()) begin
      int c = strm[i];
      if (c == 8'h40) break;
      if (c < 8'h40) begin
        for (int k = c + 1; k >= 1; k--) begin
          exp_d.push_back(strm[i+k]); exp_a.push_back(a); exp_r.push_back("R3"); a++;
        end
        i += c + 2;
      end else if (c < 8'h80) begin
        for (int k = 0; k < c - 8'h3F; k++) begin
          exp_d.push_back(8'(strm[i+1] + k)); exp_a.push_back(a); exp_r.push_back("R5"); a++;
        end
        i += 2;
      end else if (c < 8'hA0) begin
        for (int k = 0; k < c - 8'h7F; k++) begin
          exp_d.push_back((k % 2 == 0) ? strm[i+1] : strm[i+2]);
          exp_a.push_back(a); exp_r.push_back("R6"); a++;
        end
        i += 3;
      end else begin
        for (int k = 0; k < 257 - c; k++) begin
          exp_d.push_back(strm[i+1]); exp_a.push_back(a); exp_r.push_back("R7"); a++;
        end
        i += 2;
      end
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] base);
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10", "done after start", done, 0);
  endtask

  task automatic drive_from(input int first, input int gap_pct);
    int i = first;
    while (i < strm.size() && !wd_hit) begin
      bit fire;
      @(negedge clk);
      in_valid = (int'(rnd() % 100) >= gap_pct);
      in_data  = strm[i];
      fire     = in_valid && in_ready;
      @(posedge clk);
      if (fire) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit fire = 1'b0;
    while (!fire && !wd_hit) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      fire     = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int ready_pct);
    int got = 0;
    while (got < exp_d.size() && !wd_hit) begin
      @(negedge clk);
      out_ready = (int'(rnd() % 100) < ready_pct);
      if (out_valid && out_ready) begin
        chk(out_data == exp_d[got], exp_r[got], $sformatf("data #%0d", got),
            out_data, exp_d[got]);
        chk(out_addr == exp_a[got], "R2", $sformatf("addr #%0d", got),
            out_addr, exp_a[got]);
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic finish_stream();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R4", "done after terminator", done, 1);
    in_valid = 1'b1;
    in_data  = 8'hA5;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R4", "input closed and no output while done",
          {in_ready, out_valid}, 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; base_addr = '0;
    in_data = '0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!out_valid && !in_ready && !done, "R1", "idle before start",
          {out_valid, in_ready, done}, 0);
    end
    in_valid = 1'b0;

    // Sweep of every command value except the terminator (R3, R5, R6, R7).
    strm.delete();
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h40) continue;
      strm.push_back(8'(c));
      if (c < 8'h40) for (int k = 0; k <= c; k++) strm.push_back(8'(rnd()));
      else if (c >= 8'h80 && c < 8'hA0) begin
        strm.push_back(8'(rnd())); strm.push_back(8'(rnd()));
      end else strm.push_back(8'(rnd()));
    end
    strm.push_back(8'h40);
    model(16'h1230);
    pulse_start(16'h1230);
    fork
      drive_from(0, 30);
      collect(60);
    join
    finish_stream();

    // Stall during a 97-byte run (R9, R8), then a wrapping sequence (R5).
    strm = '{8'hA0, 8'h5A, 8'h43, 8'hFE, 8'h40};
    model(16'h0100);
    out_ready = 1'b0;
    pulse_start(16'h0100);
    send_byte(8'hA0);
    send_byte(8'h5A);
    in_valid = 1'b1;
    in_data  = 8'h43;
    for (int k = 0; k < 30; k++) @(negedge clk);
    chk(in_ready == 1'b0, "R9", "input held off while run pending", in_ready, 0);
    chk(out_valid == 1'b1, "R8", "pending byte valid", out_valid, 1);
    chk(out_data == 8'h5A, "R8", "pending byte stable", out_data, 8'h5A);
    chk(out_addr == 16'h0100, "R2", "first address is base", out_addr, 16'h0100);
    in_valid = 1'b0;
    fork
      drive_from(2, 0);
      collect(50);
    join
    finish_stream();

    // Restart after completion with an address that wraps (R10, R2, R3, R6).
    strm = '{8'h01, 8'h11, 8'h22, 8'h80, 8'h33, 8'h44, 8'hFF, 8'h77, 8'h40};
    model(16'hFFFE);
    pulse_start(16'hFFFE);
    fork
      drive_from(0, 20);
      collect(100);
    join
    finish_stream();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule